// File: doc/BRIEF.md
# Debug Module Register Front-End

This block is the register file that an external debugger reaches over a debug transport. The transport delivers one request at a time: an address, a read/write flag and 32 bits of write data. The block answers exactly one cycle later with read data and an error flag. Behind the registers it holds the debug session state:

- control and the selected hart index;
- per-hart halt requests, resume flags and resume acknowledges;
- the abstract-command error code and busy flag;
- the auto-execute masks;
- a small data window and a small program-buffer window.

The hart side of the chip reports halt and resume events with a hart index. The command engine reports completion and exceptions. When an abstract command passes validation, the block launches it with a one-cycle `cmd_go` pulse. The same launch path is reached from a command write and from an auto-execute hit on the data or program-buffer windows.

Top module: `dbg_regfront`

## Requirements
- R1: After reset the status register (0x11) reads authenticated (bit 7) = 1 and version (bits 3:0) = 2. The abstract status register (0x16) reads data word count in bits 3:0, program-buffer size in bits 28:24, busy (bit 12) = 0 and error code (bits 10:8) = 0.
- R2: A control write (0x10) with active (bit 0) clear returns control, the auto-execute masks, the error code, the busy flag and every halt request to zero. Only a write with active set captures haltreq (bit 31), resumereq (bit 30), hart select (bits 19:16) and ndmreset (bit 1). A captured haltreq drives the halt request of the selected hart only.
- R3: A control write with active and resumereq set raises the selected hart's resume flag and clears its resume acknowledge. A resume event from that hart drops the flag and sets the acknowledge.
- R4: A status read reports the selected hart as follows:
  - halted (bits 9/8) when it exists and is halted;
  - running (bits 11/10) when it exists and is not halted;
  - nonexistent (bits 15/14) when the index is not below the hart count;
  - resume-acknowledged (bits 17/16) when it exists and has acknowledged.

  In each pair the "any" bit equals the "all" bit.
- R5: A read or write of a data word (0x04 + i) while busy sets the error code to BUSY (1), but only when the error code is NONE (0).
- R6: An access to data word i re-runs the stored command when bit i of the data auto-execute mask (0x18 bits 11:0) is set. An access to program-buffer word i (0x20 + i) does the same when bit i of the program auto-execute mask (0x18 bits 31:16) is set. Accesses to words whose mask bit is clear launch nothing.
- R7: A write to the abstract status register clears the error-code bits that are one in bits 10:8 of the write data. A read of the command register (0x17) returns zero.
- R8: The hart info register (0x12) reads as follows:
  - 1 scratch register in bits 23:20;
  - data-access bit 16 = 1;
  - the data word count in bits 15:12;
  - the data address in bits 11:0.
- R9: Any access to an unmapped address returns zero data with the error flag set for that one response.
- R10: Every request produces exactly one response, one cycle after the request strobe, and no response appears without a request.
- R11: Command launch and command errors:
  - A launch is ignored while the error code is nonzero.
  - A launch while busy sets BUSY (1).
  - A command type (bits 31:24) other than 0 sets NOTSUP (2).
  - A command to a hart that is not halted sets HALTRESUME (4).
  - A transfer (bit 17) with register number (bits 15:0) outside 0x1000–0x101F, or with size (bits 22:20) other than 2 or 3, sets NOTSUP.
  - Any other command sets busy and pulses `cmd_go` with the command word.
  - `cmd_done` clears busy. `cmd_exc` sets EXCEPTION (3) when the error code is NONE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Register address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 32 | Read data, zero for writes |
| rsp_err | output | 1 | Access to an unmapped address |
| hart_halt_ev | input | 1 | Hart reports it has halted |
| hart_resume_ev | input | 1 | Hart reports it has resumed |
| hart_ev_id | input | HSEL_W | Index of the reporting hart |
| cmd_done | input | 1 | Command engine finished |
| cmd_exc | input | 1 | Command raised an exception |
| halt_req | output | NUM_HARTS | Per-hart halt request |
| resume_req | output | NUM_HARTS | Per-hart resume flag |
| ndm_reset | output | 1 | Non-debug-module reset request |
| cmd_go | output | 1 | One-cycle command launch |
| cmd_word | output | 32 | Command word being launched |
| cmd_busy | output | 1 | A command is in flight |

## Verification
The error-code logic gets the most attention from the bench.

- **Sticky error.** A data access while busy is done once with a clear error code and once with EXCEPTION already latched. A design that overwrote the error would turn that 3 into 1.
- **Write-one-to-clear.** The abstract status register is written with zeros and then with ones. A design that stored the written value instead of clearing bits would fail one of the two writes.
- **Rejected commands.** The bench sends a wrong command type, a command to a running hart, register numbers just outside the legal range and an unsupported size. Each must set its own code and must not pulse `cmd_go`.
- **Auto-execute.** Only the masked words may launch the command. A design that ignored the word index would launch on every access.
- **Deactivation.** A write with active clear must leave masks, errors and halt requests cleared and must capture no fields.

// File: rtl/dbg_regfront_pkg.sv
// Package: shared address map, error codes and command verdicts for the
// debug module register front-end.
package dbg_regfront_pkg;

    localparam int ADDR_W = 7;

    localparam logic [ADDR_W-1:0] A_DATA0  = 7'h04;
    localparam logic [ADDR_W-1:0] A_CTRL   = 7'h10;
    localparam logic [ADDR_W-1:0] A_STATUS = 7'h11;
    localparam logic [ADDR_W-1:0] A_HINFO  = 7'h12;
    localparam logic [ADDR_W-1:0] A_ACS    = 7'h16;
    localparam logic [ADDR_W-1:0] A_CMD    = 7'h17;
    localparam logic [ADDR_W-1:0] A_AUTO   = 7'h18;
    localparam logic [ADDR_W-1:0] A_PROG0  = 7'h20;

    localparam logic [3:0] VERSION_CODE = 4'd2;

    typedef enum logic [2:0] {
        ERR_NONE    = 3'd0,
        ERR_BUSY    = 3'd1,
        ERR_NOTSUP  = 3'd2,
        ERR_EXC     = 3'd3,
        ERR_HALTRES = 3'd4
    } cmderr_e;

    typedef enum logic [1:0] {
        V_OK,
        V_NOTSUP,
        V_HALTRES
    } verdict_e;

endpackage

// File: rtl/dbg_word_window.sv
// Module: dbg_word_window
// A small bank of 32-bit words written and read by word index.
// Assumes the caller only presents indices below WORDS; reset clears all words.
module dbg_word_window #(
    parameter int WORDS = 2,
    parameter int IDX_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data
);

    logic [31:0] words [WORDS];

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        // Store one word when it is addressed by a write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                words[i] <= wr_data;
            end
        end
    end

    // Select the addressed word for reading.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = words[i];
        end
    end

endmodule

// File: rtl/dbg_hart_state.sv
// Module: dbg_hart_state
// Per-hart debug state: halted, resume acknowledge, resume flag, halt request.
// Also looks up the state of the currently selected hart.
// Assumes hart events and control writes do not target the same hart in the
// same cycle; when they do, the hart event wins.
module dbg_hart_state #(
    parameter int NUM_HARTS = 4,
    parameter int HSEL_W    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr_all,
    input  logic                 ctrl_wr,
    input  logic [HSEL_W-1:0]    ctrl_sel,
    input  logic                 ctrl_haltreq,
    input  logic                 ctrl_resumereq,
    input  logic                 halt_ev,
    input  logic                 resume_ev,
    input  logic [HSEL_W-1:0]    ev_id,
    input  logic [HSEL_W-1:0]    cur_sel,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic [NUM_HARTS-1:0] resume_req,
    output logic                 sel_exists,
    output logic                 sel_halted,
    output logic                 sel_ack
);

    logic [NUM_HARTS-1:0] halted_v;
    logic [NUM_HARTS-1:0] ack_v;

    for (genvar i = 0; i < NUM_HARTS; i++) begin : g_hart
        localparam logic [HSEL_W-1:0] ID = HSEL_W'(i);
        logic h_q, a_q, r_q, q_q;
        logic ev_me, ctl_me;

        assign ev_me  = (ev_id == ID);
        assign ctl_me = ctrl_wr && (ctrl_sel == ID);

        // Track halted state from the hart's own reports.
        always_ff @(posedge clk) begin
            if (!rst_n)                h_q <= 1'b0;
            else if (halt_ev && ev_me)   h_q <= 1'b1;
            else if (resume_ev && ev_me) h_q <= 1'b0;
        end

        // Resume acknowledge: set by resume report, cleared by a new resume request.
        always_ff @(posedge clk) begin
            if (!rst_n)                          a_q <= 1'b0;
            else if (resume_ev && ev_me)         a_q <= 1'b1;
            else if (ctl_me && ctrl_resumereq)   a_q <= 1'b0;
        end

        // Resume flag: raised by a resume request, dropped once the hart resumes.
        always_ff @(posedge clk) begin
            if (!rst_n)                          r_q <= 1'b0;
            else if (resume_ev && ev_me)         r_q <= 1'b0;
            else if (ctl_me && ctrl_resumereq)   r_q <= 1'b1;
        end

        // Halt request: follows the haltreq bit of control writes to this hart.
        always_ff @(posedge clk) begin
            if (!rst_n)       q_q <= 1'b0;
            else if (clr_all) q_q <= 1'b0;
            else if (ctl_me)  q_q <= ctrl_haltreq;
        end

        assign halted_v[i]   = h_q;
        assign ack_v[i]      = a_q;
        assign resume_req[i] = r_q;
        assign halt_req[i]   = q_q;
    end

    // Look up the selected hart; an index past the last hart does not exist.
    always_comb begin
        sel_exists = 1'b0;
        sel_halted = 1'b0;
        sel_ack    = 1'b0;
        for (int i = 0; i < NUM_HARTS; i++) begin
            if (cur_sel == HSEL_W'(i)) begin
                sel_exists = 1'b1;
                sel_halted = halted_v[i];
                sel_ack    = ack_v[i];
            end
        end
    end

endmodule

// File: rtl/dbg_cmd_check.sv
// Module: dbg_cmd_check
// Decides whether an abstract command may launch.
// Purely combinational; assumes register numbers 0x1000..0x101F are the only
// transferable ones and that sizes 2 and 3 are the only supported widths.
module dbg_cmd_check
    import dbg_regfront_pkg::*;
(
    input  logic [7:0]  cmd_type,
    input  logic [2:0]  cmd_size,
    input  logic        cmd_transfer,
    input  logic [15:0] cmd_regno,
    input  logic        sel_halted,
    output verdict_e    verdict
);

    // Rank the checks: type first, then hart state, then transfer legality.
    always_comb begin
        verdict = V_OK;
        if (cmd_type != 8'd0) begin
            verdict = V_NOTSUP;
        end else if (!sel_halted) begin
            verdict = V_HALTRES;
        end else if (cmd_transfer) begin
            if (cmd_regno < 16'h1000 || cmd_regno > 16'h101F) verdict = V_NOTSUP;
            else if (cmd_size != 3'd2 && cmd_size != 3'd3)    verdict = V_NOTSUP;
        end
    end

endmodule

// File: rtl/dbg_regfront.sv
// Module: dbg_regfront
// Register front-end of the debug module: decodes transport requests, keeps
// control, abstract-command status and auto-execute state, answers every
// request one cycle later and launches abstract commands.
// Assumes one request per strobe and DATA_WORDS <= 12, PROG_WORDS <= 16.
module dbg_regfront
    import dbg_regfront_pkg::*;
#(
    parameter int          NUM_HARTS  = 4,
    parameter int          HSEL_W     = 4,
    parameter int          DATA_WORDS = 2,
    parameter int          PROG_WORDS = 4,
    parameter logic [11:0] DATA_ADDR  = 12'h380
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [6:0]           req_addr,
    input  logic [31:0]          req_wdata,
    output logic                 rsp_valid,
    output logic [31:0]          rsp_rdata,
    output logic                 rsp_err,
    input  logic                 hart_halt_ev,
    input  logic                 hart_resume_ev,
    input  logic [HSEL_W-1:0]    hart_ev_id,
    input  logic                 cmd_done,
    input  logic                 cmd_exc,
    output logic [NUM_HARTS-1:0] halt_req,
    output logic [NUM_HARTS-1:0] resume_req,
    output logic                 ndm_reset,
    output logic                 cmd_go,
    output logic [31:0]          cmd_word,
    output logic                 cmd_busy
);

    localparam int DIDX_W = (DATA_WORDS > 1) ? $clog2(DATA_WORDS) : 1;
    localparam int PIDX_W = (PROG_WORDS > 1) ? $clog2(PROG_WORDS) : 1;

    // Control and abstract state.
    logic              ctl_active, ctl_haltreq, ctl_resumereq, ctl_ndm;
    logic [HSEL_W-1:0] hartsel;
    cmderr_e           cmderr, cmderr_n;
    logic              busy, busy_n, go_n;
    logic [DATA_WORDS-1:0] auto_data;
    logic [PROG_WORDS-1:0] auto_prog;
    logic [31:0]       cmd_reg;

    // Decode.
    logic [ADDR_W-1:0] off_d, off_p;
    logic              is_data, is_prog, is_known;
    logic [DIDX_W-1:0] didx;
    logic [PIDX_W-1:0] pidx;
    logic              wr, acc_data, acc_prog;
    logic              wr_ctrl, wr_cmd, wr_acs, wr_auto, deact;
    logic              auto_hit, perform;
    logic [31:0]       perform_word;
    logic [31:0]       data_rd, prog_rd, rdata_c;
    logic              sel_exists, sel_halted, sel_ack;
    verdict_e          verdict;

    // Work out which window or register the request addresses.
    always_comb begin
        off_d   = req_addr - A_DATA0;
        off_p   = req_addr - A_PROG0;
        is_data = (req_addr >= A_DATA0) && (off_d < ADDR_W'(DATA_WORDS));
        is_prog = (req_addr >= A_PROG0) && (off_p < ADDR_W'(PROG_WORDS));
        didx    = off_d[DIDX_W-1:0];
        pidx    = off_p[PIDX_W-1:0];
        is_known = is_data || is_prog ||
                   req_addr == A_CTRL || req_addr == A_STATUS ||
                   req_addr == A_HINFO || req_addr == A_ACS ||
                   req_addr == A_CMD || req_addr == A_AUTO;
    end

    // Form per-register strobes and the command launch request.
    always_comb begin
        wr       = req_valid && req_write;
        acc_data = req_valid && is_data;
        acc_prog = req_valid && is_prog;
        wr_ctrl  = wr && req_addr == A_CTRL;
        wr_cmd   = wr && req_addr == A_CMD;
        wr_acs   = wr && req_addr == A_ACS;
        wr_auto  = wr && req_addr == A_AUTO;
        deact    = wr_ctrl && !req_wdata[0];
        auto_hit = (acc_data && auto_data[didx]) || (acc_prog && auto_prog[pidx]);
        perform  = wr_cmd || auto_hit;
        perform_word = wr_cmd ? req_wdata : cmd_reg;
    end

    dbg_word_window #(.WORDS(DATA_WORDS), .IDX_W(DIDX_W)) u_data (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr && is_data),
        .wr_idx  (didx),
        .wr_data (req_wdata),
        .rd_idx  (didx),
        .rd_data (data_rd)
    );

    dbg_word_window #(.WORDS(PROG_WORDS), .IDX_W(PIDX_W)) u_prog (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr && is_prog),
        .wr_idx  (pidx),
        .wr_data (req_wdata),
        .rd_idx  (pidx),
        .rd_data (prog_rd)
    );

    dbg_hart_state #(.NUM_HARTS(NUM_HARTS), .HSEL_W(HSEL_W)) u_harts (
        .clk            (clk),
        .rst_n          (rst_n),
        .clr_all        (deact),
        .ctrl_wr        (wr_ctrl && req_wdata[0]),
        .ctrl_sel       (req_wdata[16 +: HSEL_W]),
        .ctrl_haltreq   (req_wdata[31]),
        .ctrl_resumereq (req_wdata[30]),
        .halt_ev        (hart_halt_ev),
        .resume_ev      (hart_resume_ev),
        .ev_id          (hart_ev_id),
        .cur_sel        (hartsel),
        .halt_req       (halt_req),
        .resume_req     (resume_req),
        .sel_exists     (sel_exists),
        .sel_halted     (sel_halted),
        .sel_ack        (sel_ack)
    );

    dbg_cmd_check u_check (
        .cmd_type     (perform_word[31:24]),
        .cmd_size     (perform_word[22:20]),
        .cmd_transfer (perform_word[17]),
        .cmd_regno    (perform_word[15:0]),
        .sel_halted   (sel_halted),
        .verdict      (verdict)
    );

    // Next error code, busy flag and launch pulse, in rising priority.
    always_comb begin
        cmderr_n = cmderr;
        busy_n   = busy;
        go_n     = 1'b0;
        if (cmd_done) busy_n = 1'b0;
        if (cmd_exc && cmderr_n == ERR_NONE) cmderr_n = ERR_EXC;
        if (acc_data && busy && cmderr_n == ERR_NONE) cmderr_n = ERR_BUSY;
        if (perform && cmderr_n == ERR_NONE) begin
            if (busy) begin
                cmderr_n = ERR_BUSY;
            end else begin
                case (verdict)
                    V_OK:      begin busy_n = 1'b1; go_n = 1'b1; end
                    V_HALTRES: cmderr_n = ERR_HALTRES;
                    default:   cmderr_n = ERR_NOTSUP;
                endcase
            end
        end
        if (wr_acs) cmderr_n = cmderr_e'(cmderr_n & ~req_wdata[10:8]);
        if (deact) begin
            cmderr_n = ERR_NONE;
            busy_n   = 1'b0;
            go_n     = 1'b0;
        end
    end

    // Hold the abstract-command state and the launch outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmderr   <= ERR_NONE;
            busy     <= 1'b0;
            cmd_go   <= 1'b0;
            cmd_word <= '0;
            cmd_reg  <= '0;
        end else begin
            cmderr <= cmderr_n;
            busy   <= busy_n;
            cmd_go <= go_n;
            if (go_n)   cmd_word <= perform_word;
            if (wr_cmd) cmd_reg  <= req_wdata;
        end
    end

    // Hold control fields; capture only while active, clear on deactivation.
    always_ff @(posedge clk) begin
        if (!rst_n || deact) begin
            ctl_active    <= 1'b0;
            ctl_haltreq   <= 1'b0;
            ctl_resumereq <= 1'b0;
            ctl_ndm       <= 1'b0;
            hartsel       <= '0;
        end else if (wr_ctrl) begin
            ctl_active    <= 1'b1;
            ctl_haltreq   <= req_wdata[31];
            ctl_resumereq <= req_wdata[30];
            ctl_ndm       <= req_wdata[1];
            hartsel       <= req_wdata[16 +: HSEL_W];
        end
    end

    // Hold the auto-execute masks.
    always_ff @(posedge clk) begin
        if (!rst_n || deact) begin
            auto_data <= '0;
            auto_prog <= '0;
        end else if (wr_auto) begin
            auto_data <= req_wdata[0 +: DATA_WORDS];
            auto_prog <= req_wdata[16 +: PROG_WORDS];
        end
    end

    // Assemble read data for the addressed register.
    always_comb begin
        rdata_c = '0;
        if (is_data) begin
            rdata_c = data_rd;
        end else if (is_prog) begin
            rdata_c = prog_rd;
        end else begin
            case (req_addr)
                A_CTRL: begin
                    rdata_c[31]            = ctl_haltreq;
                    rdata_c[30]            = ctl_resumereq;
                    rdata_c[16 +: HSEL_W]  = hartsel;
                    rdata_c[1]             = ctl_ndm;
                    rdata_c[0]             = ctl_active;
                end
                A_STATUS: begin
                    rdata_c[3:0]  = VERSION_CODE;
                    rdata_c[7]    = 1'b1;
                    rdata_c[9]    = sel_exists && sel_halted;
                    rdata_c[8]    = sel_exists && sel_halted;
                    rdata_c[11]   = sel_exists && !sel_halted;
                    rdata_c[10]   = sel_exists && !sel_halted;
                    rdata_c[15]   = !sel_exists;
                    rdata_c[14]   = !sel_exists;
                    rdata_c[17]   = sel_exists && sel_ack;
                    rdata_c[16]   = sel_exists && sel_ack;
                end
                A_HINFO: begin
                    rdata_c[23:20] = 4'd1;
                    rdata_c[16]    = 1'b1;
                    rdata_c[15:12] = 4'(DATA_WORDS);
                    rdata_c[11:0]  = DATA_ADDR;
                end
                A_ACS: begin
                    rdata_c[28:24] = 5'(PROG_WORDS);
                    rdata_c[12]    = busy;
                    rdata_c[10:8]  = cmderr;
                    rdata_c[3:0]   = 4'(DATA_WORDS);
                end
                A_AUTO: begin
                    rdata_c[16 +: PROG_WORDS] = auto_prog;
                    rdata_c[0 +: DATA_WORDS]  = auto_data;
                end
                default: rdata_c = '0;
            endcase
        end
    end

    // Register the response one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && !is_known;
            rsp_rdata <= (req_valid && !req_write && is_known) ? rdata_c : '0;
        end
    end

    assign ndm_reset = ctl_ndm;
    assign cmd_busy  = busy;

endmodule

// File: rtl/dbg_regfront_chk.sv
// Module: dbg_regfront_chk
// Property checker for the register front-end, bound to every instance.
// Assumes the synchronous active-low reset of the checked block.
module dbg_regfront_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        cmd_go,
    input logic        cmd_busy
);

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    assert_err_zero_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 32'd0 && rsp_valid));

    assert_go_sets_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |-> cmd_busy);

    assert_go_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_go |=> !cmd_go);

endmodule

bind dbg_regfront dbg_regfront_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .cmd_go    (cmd_go),
    .cmd_busy  (cmd_busy)
);

// File: tb/dbg_regfront_bench.sv
`timescale 1ns/1ps
// Scoreboard bench for dbg_regfront: the driver queues expected responses,
// the monitor pops and compares them as responses appear.
module dbg_regfront_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [6:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic        hart_halt_ev = 1'b0, hart_resume_ev = 1'b0;
    logic [3:0]  hart_ev_id = '0;
    logic        cmd_done = 1'b0, cmd_exc = 1'b0;
    logic [3:0]  halt_req, resume_req;
    logic        ndm_reset, cmd_go, cmd_busy;
    logic [31:0] cmd_word;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] exp_d [$];
    logic        exp_e [$];
    string       exp_t [$];

    localparam logic [31:0] ACS0 = 32'h0400_0002;
    localparam logic [31:0] CMDV = 32'h0022_1005;

    always #10 clk = ~clk;

    dbg_regfront u_dbg_regfront (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .rsp_err(rsp_err), .hart_halt_ev(hart_halt_ev),
        .hart_resume_ev(hart_resume_ev), .hart_ev_id(hart_ev_id),
        .cmd_done(cmd_done), .cmd_exc(cmd_exc), .halt_req(halt_req),
        .resume_req(resume_req), .ndm_reset(ndm_reset), .cmd_go(cmd_go),
        .cmd_word(cmd_word), .cmd_busy(cmd_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare each response with the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_d.size() == 0) begin
                n_vec++; n_bad++;
                $display("FAIL R10 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                automatic logic [31:0] d = exp_d.pop_front();
                automatic logic        e = exp_e.pop_front();
                automatic string       t = exp_t.pop_front();
                chk({t, " data"}, rsp_rdata, d);
                chk({t, " err"}, {31'd0, rsp_err}, {31'd0, e});
            end
        end
    end

    task automatic xfer(input logic w, input logic [6:0] a, input logic [31:0] d,
                        input logic [31:0] ed, input logic ee, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        exp_d.push_back(ed); exp_e.push_back(ee); exp_t.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] ed, input string tag);
        xfer(1'b0, a, 32'd0, ed, 1'b0, tag);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d, input string tag);
        xfer(1'b1, a, d, 32'd0, 1'b0, tag);
    endtask

    // kind: 0 halt event, 1 resume event, 2 command done, 3 command exception
    task automatic pulse(input int kind, input logic [3:0] id);
        @(negedge clk);
        hart_ev_id = id;
        case (kind)
            0: hart_halt_ev = 1'b1;
            1: hart_resume_ev = 1'b1;
            2: cmd_done = 1'b1;
            default: cmd_exc = 1'b1;
        endcase
        @(negedge clk);
        hart_halt_ev = 1'b0; hart_resume_ev = 1'b0; cmd_done = 1'b0; cmd_exc = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_vec++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R4 / R8 / R7 / R9: reset state and fixed registers
        chk("R1 halt_req after reset", {28'd0, halt_req}, 32'd0);
        chk("R1 busy after reset", {31'd0, cmd_busy}, 32'd0);
        rd(7'h11, 32'h0000_0C82, "R1 R4 status at reset");
        rd(7'h16, ACS0, "R1 abstract status at reset");
        rd(7'h12, 32'h0011_2380, "R8 hart info");
        rd(7'h17, 32'd0, "R7 command reads zero");
        xfer(1'b0, 7'h7F, 32'd0, 32'd0, 1'b1, "R9 unmapped read");
        xfer(1'b1, 7'h13, 32'hFFFF_FFFF, 32'd0, 1'b1, "R9 unmapped write");

        // R2: fields ignored while inactive
        wr(7'h10, 32'h8002_0000, "R2 inactive write");
        chk("R2 no halt request when inactive", {28'd0, halt_req}, 32'd0);
        rd(7'h10, 32'd0, "R2 control stays clear");

        // R2: capture with active set
        wr(7'h10, 32'h8001_0001, "R2 active write");
        chk("R2 halt request to hart 1", {28'd0, halt_req}, 32'h2);
        rd(7'h10, 32'h8001_0001, "R2 control readback");

        // R4: halted, then nonexistent
        pulse(0, 4'd1);
        rd(7'h11, 32'h0000_0382, "R4 selected hart halted");
        wr(7'h10, 32'h0005_0001, "R4 select missing hart");
        rd(7'h11, 32'h0000_C082, "R4 selected hart nonexistent");
        wr(7'h10, 32'h0001_0001, "R4 reselect hart 1");
        chk("R2 halt request dropped", {28'd0, halt_req}, 32'd0);

        // R11: good launch
        wr(7'h17, CMDV, "R11 launch");
        chk("R11 go pulse", {31'd0, cmd_go}, 32'd1);
        chk("R11 launched word", cmd_word, CMDV);
        rd(7'h16, ACS0 | 32'h1000, "R11 busy set");

        // R5: data access while busy sets BUSY
        wr(7'h04, 32'h1234_5678, "R5 data write while busy");
        rd(7'h16, ACS0 | 32'h1100, "R5 BUSY error");
        wr(7'h17, CMDV, "R11 launch with error pending");
        chk("R11 no go while error", {31'd0, cmd_go}, 32'd0);
        pulse(2, 4'd0);
        rd(7'h16, ACS0 | 32'h0100, "R11 done clears busy");

        // R7: write-one-to-clear
        wr(7'h16, 32'h0000_0000, "R7 zero write");
        rd(7'h16, ACS0 | 32'h0100, "R7 zero keeps error");
        wr(7'h16, 32'h0000_0100, "R7 one clears");
        rd(7'h16, ACS0, "R7 error cleared");

        // R11: bad type
        wr(7'h17, 32'h0100_0000, "R11 bad type");
        chk("R11 bad type no go", {31'd0, cmd_go}, 32'd0);
        rd(7'h16, ACS0 | 32'h0200, "R11 NOTSUP on type");
        wr(7'h16, 32'h0000_0700, "R7 clear");

        // R5: BUSY not written over an existing error; R11 exception code
        wr(7'h17, CMDV, "R11 second launch");
        chk("R11 second go", {31'd0, cmd_go}, 32'd1);
        pulse(3, 4'd0);
        rd(7'h16, ACS0 | 32'h1300, "R11 exception code");
        rd(7'h05, 32'd0, "R5 data read while busy");
        rd(7'h16, ACS0 | 32'h1300, "R5 existing error kept");
        pulse(2, 4'd0);
        wr(7'h16, 32'h0000_0700, "R7 clear");

        // R11: hart not halted
        wr(7'h10, 32'h0002_0001, "R11 select running hart");
        wr(7'h17, CMDV, "R11 launch on running hart");
        chk("R11 running hart no go", {31'd0, cmd_go}, 32'd0);
        rd(7'h16, ACS0 | 32'h0400, "R11 HALTRESUME");
        wr(7'h16, 32'h0000_0700, "R7 clear");
        wr(7'h10, 32'h0001_0001, "R11 reselect hart 1");

        // R11: register number and size limits
        wr(7'h17, 32'h0022_0FFF, "R11 regno below");
        rd(7'h16, ACS0 | 32'h0200, "R11 regno below NOTSUP");
        wr(7'h16, 32'h0000_0700, "R7 clear");
        wr(7'h17, 32'h0022_1020, "R11 regno above");
        rd(7'h16, ACS0 | 32'h0200, "R11 regno above NOTSUP");
        wr(7'h16, 32'h0000_0700, "R7 clear");
        wr(7'h17, 32'h0042_1000, "R11 bad size");
        rd(7'h16, ACS0 | 32'h0200, "R11 size NOTSUP");
        wr(7'h16, 32'h0000_0700, "R7 clear");
        wr(7'h17, 32'h0000_0000, "R11 no-transfer command");
        chk("R11 no-transfer go", {31'd0, cmd_go}, 32'd1);
        pulse(2, 4'd0);

        // R6: auto-execute masks
        wr(7'h22, 32'hCAFE_0002, "R6 fill program word 2");
        wr(7'h18, 32'h0004_0002, "R6 set masks");
        rd(7'h18, 32'h0004_0002, "R6 mask readback");
        wr(7'h04, 32'h0000_0011, "R6 data 0 unmasked");
        chk("R6 data 0 no go", {31'd0, cmd_go}, 32'd0);
        wr(7'h05, 32'h0000_0022, "R6 data 1 masked");
        chk("R6 data 1 go", {31'd0, cmd_go}, 32'd1);
        pulse(2, 4'd0);
        rd(7'h04, 32'h0000_0011, "R6 data 0 readback");
        chk("R6 data 0 read no go", {31'd0, cmd_go}, 32'd0);
        rd(7'h22, 32'hCAFE_0002, "R6 program word 2 read");
        chk("R6 program 2 go", {31'd0, cmd_go}, 32'd1);
        pulse(2, 4'd0);
        rd(7'h21, 32'd0, "R6 program word 1 read");
        chk("R6 program 1 no go", {31'd0, cmd_go}, 32'd0);

        // R3: resume handshake
        wr(7'h10, 32'h4001_0001, "R3 resume request");
        chk("R3 resume flag raised", {28'd0, resume_req}, 32'h2);
        rd(7'h11, 32'h0000_0382, "R3 no ack yet");
        pulse(1, 4'd1);
        chk("R3 resume flag dropped", {28'd0, resume_req}, 32'd0);
        rd(7'h11, 32'h0003_0C82, "R3 R4 resumed and acknowledged");
        rd(7'h10, 32'h4001_0001, "R2 resumereq readback");

        // R2: deactivation clears state
        wr(7'h10, 32'h8001_0003, "R2 halt again with ndmreset");
        chk("R2 ndmreset", {31'd0, ndm_reset}, 32'd1);
        wr(7'h17, 32'h0100_0000, "R2 leave an error");
        wr(7'h10, 32'h0000_0000, "R2 deactivate");
        chk("R2 halt requests cleared", {28'd0, halt_req}, 32'd0);
        chk("R2 ndmreset cleared", {31'd0, ndm_reset}, 32'd0);
        rd(7'h10, 32'd0, "R2 control cleared");
        rd(7'h18, 32'd0, "R2 masks cleared");
        rd(7'h16, ACS0, "R2 error cleared");
        rd(7'h11, 32'h0000_0C82, "R2 R4 back on hart 0");

        repeat (3) @(negedge clk);
        chk("R10 all responses seen", exp_d.size(), 32'd0);
        finish_run();
    end

endmodule